// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-driven master for the two-wire PHY management bus. Software writes one 32-bit maintenance word. When the port is enabled and no transaction is running, that write launches a single clause-22 frame. The block first sends a preamble of 32 MDC cycles with MDIO held high. It then shifts the maintenance word out unchanged, most significant bit first. The start code, opcode, PHY address, register number, turnaround code and data therefore reach the wire exactly as software placed them in the word, and no separate field registers are needed.

For a read, the block stops driving MDIO from the second turnaround bit onward. It samples the 16 data bits the PHY returns on rising MDC edges, and when the frame ends it writes them into the low half of the maintenance word. A missing PHY leaves the line pulled high, so the result reads as 0xFFFF. A status flag reports when the port is enabled and free, and software polls it before and after each command. MDC is the system clock divided by 32 or 48, selected by a configuration input.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: `idle` is 1 only when `mgmt_en` is 1 and no frame is in progress. It is 0 from the cycle after an accepted write until the frame has finished.
- R2: While `mgmt_en` is 0, a write to the maintenance word is ignored. MDC stays low, MDIO is not driven and `maint_rdata` keeps its value.
- R3: Every frame begins with 32 MDC cycles in which MDIO is driven to 1.
- R4: After the preamble come 32 MDC cycles that carry bits 31 down to 0 of the maintenance word, one bit per cycle. MDIO changes only while MDC is low, so each bit is stable when MDC rises.
- R5: Bit 29 of the word selects a read. In a read, `mdio_oe` is 0 from the bit-16 position (the second turnaround bit) to the end of the frame. In a write, `mdio_oe` is 1 for all 64 cycles.
- R6: In a read, `mdio_i` is sampled on the 16 rising MDC edges of bit positions 15 down to 0, first sample into bit 15. At the end of the frame the samples replace bits 15:0 of the maintenance word, and bits 31:16 are kept. An absent PHY gives 0xFFFF.
- R7: After a write frame, `maint_rdata` still equals the word that was written.
- R8: With `div_sel` 0 the MDC period is 32 system clocks, and with `div_sel` 1 it is 48. The high and low halves are equal. The selection is taken when a frame starts.
- R9: A maintenance write that arrives while a frame is running, including in its final cycle, is ignored. The frame on the wire and the final register value are those of the accepted command.
- R10: While no frame is running, `mdc` is 0 and `mdio_oe` is 0.
- R11: Every frame lasts exactly 64 MDC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_en | input | 1 | Management port enable |
| div_sel | input | 1 | MDC divider select: 0 = /32, 1 = /48 |
| maint_wr | input | 1 | Write strobe for the maintenance word |
| maint_wdata | input | 32 | Maintenance word to write |
| maint_rdata | output | 32 | Current maintenance word, including read results |
| idle | output | 1 | Port enabled and ready for a command |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by this block |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value sampled from the line |

## Verification
Two things can happen in the same cycle: the commit of the captured read data into the maintenance word, and a new software write that comes in exactly as the frame finishes. The bench provokes this by holding the write strobe high with a different word on every cycle of a read frame, and it releases the strobe only after `idle` has returned. The result is judged by three checks. The register must hold the captured PHY data under the original upper half. No further MDC edge may appear afterwards. The frame bits recorded during the hammering must match the first command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // A command with the read opcode bit set turns the line around.
  function automatic logic op_is_read(input logic [31:0] word, input int unsigned rd_bit);
    return word[rd_bit];
  endfunction

  // Half of the MDC period in system clocks for the selected divide.
  function automatic int unsigned mdc_half(input logic sel, input int unsigned div_a,
                                           input int unsigned div_b);
    return (sel ? div_b : div_a) / 2;
  endfunction

  // A read releases the line from the second turnaround bit to the end.
  function automatic logic line_released(input logic rd, input int unsigned pos,
                                         input int unsigned rel_pos);
    return rd && (pos >= rel_pos);
  endfunction

  // The data phase occupies the last data_w positions of the frame.
  function automatic logic in_data_phase(input int unsigned pos, input int unsigned frame_len,
                                         input int unsigned data_w);
    return pos >= (frame_len - data_w);
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int unsigned DIV_A = 32,
  parameter int unsigned DIV_B = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  import mdio_pkg::*;

  localparam int unsigned DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int unsigned CW      = $clog2(DIV_MAX);

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;
  logic          mdc_q;

  assign half      = CW'(mdc_half(sel, DIV_A, DIV_B));
  assign rise_tick = run && (cnt == half - CW'(1));
  assign fall_tick = run && (cnt == {half[CW-2:0], 1'b0} - CW'(1));
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + CW'(1);
      if (rise_tick) mdc_q <= 1'b1;
      else if (fall_tick) mdc_q <= 1'b0;
    end
  end

  AST_TICKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_tick, fall_tick}));                                   // R8
  AST_MDC_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);                                                      // R10

endmodule

// File: rtl/mdio_shift.sv
module mdio_shift #(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              rd,
  output logic [DATA_W-1:0] cap,
  output logic              mdio_o,
  output logic              mdio_oe
);
  import mdio_pkg::*;

  localparam int unsigned FRAME   = PRE_LEN + WORD_W;
  localparam int unsigned IW      = $clog2(FRAME);
  localparam int unsigned RD_BIT  = WORD_W - 3;
  localparam int unsigned REL_POS = PRE_LEN + WORD_W - 1 - DATA_W;
  localparam logic [IW-1:0] LAST  = IW'(FRAME - 1);

  logic [FRAME-1:0] sh;
  logic [IW-1:0]    idx;
  logic             busy_q, rd_q;
  logic             released, capturing;

  assign released  = line_released(rd_q, int'(idx), REL_POS);
  assign capturing = busy_q && rd_q && rise_tick && in_data_phase(int'(idx), FRAME, DATA_W);
  assign done      = busy_q && fall_tick && (idx == LAST);
  assign busy      = busy_q;
  assign rd        = rd_q;
  assign mdio_o    = busy_q ? sh[FRAME-1] : 1'b1;
  assign mdio_oe   = busy_q && !released;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx    <= '0;
      sh     <= '1;
      cap    <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      rd_q   <= op_is_read(word, RD_BIT);
      idx    <= '0;
      sh     <= {{PRE_LEN{1'b1}}, word};
    end else if (busy_q) begin
      if (capturing) cap <= {cap[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (idx == LAST) busy_q <= 1'b0;
        else begin
          idx <= idx + IW'(1);
          sh  <= {sh[FRAME-2:0], 1'b1};
        end
      end
    end
  end

  AST_PREAMBLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx < IW'(PRE_LEN)) |-> (mdio_o && mdio_oe));             // R3
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && idx >= IW'(REL_POS)) |-> !mdio_oe);               // R5
  AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdio_oe);                                               // R10

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int unsigned DIV_A   = 32,
  parameter int unsigned DIV_B   = 48,
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mgmt_en,
  input  logic              div_sel,
  input  logic              maint_wr,
  input  logic [WORD_W-1:0] maint_wdata,
  output logic [WORD_W-1:0] maint_rdata,
  output logic              idle,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  logic [WORD_W-1:0] maint_q;
  logic [DATA_W-1:0] cap;
  logic              accept, busy, done, rd, sel_q, rise_tick, fall_tick;

  assign accept      = maint_wr && mgmt_en && !busy;
  assign idle        = mgmt_en && !busy;
  assign maint_rdata = maint_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maint_q <= '0;
      sel_q   <= 1'b0;
    end else if (accept) begin
      maint_q <= maint_wdata;
      sel_q   <= div_sel;
    end else if (done && rd) begin
      maint_q[DATA_W-1:0] <= cap;
    end
  end

  mdio_clkdiv #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .sel(sel_q),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_shift #(.PRE_LEN(PRE_LEN), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(accept), .word(maint_wdata),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .done(done), .rd(rd), .cap(cap),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && maint_wr && !done) |=> (maint_q == $past(maint_q)));        // R9
  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!mgmt_en && !busy) |=> !busy);                                      // R2
  AST_MDIO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));                            // R4
  AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !idle);                                                   // R1

endmodule

// File: tb/sim_mdio_frame_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_frame_ctrl;

  logic        clk = 1'b0, rst_n = 1'b0, mgmt_en = 1'b0, div_sel = 1'b0;
  logic        maint_wr = 1'b0, mdio_i = 1'b1;
  logic [31:0] maint_wdata = '0;
  logic [31:0] maint_rdata;
  logic        idle, mdc, mdio_o, mdio_oe;

  int checks = 0, errors = 0, cyc = 0, rc = 0;
  logic        obs_o [64];
  logic        obs_oe[64];
  realtime     t_rise[2];
  logic        present = 1'b0;
  logic [15:0] resp = '0;

  always #4 clk = ~clk;

  mdio_frame_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .div_sel(div_sel),
    .maint_wr(maint_wr), .maint_wdata(maint_wdata), .maint_rdata(maint_rdata),
    .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // Recorder of each rising MDC edge.
  always @(posedge mdc) begin
    if (rc < 64) begin
      obs_o[rc]  = mdio_o;
      obs_oe[rc] = mdio_oe;
    end
    if (rc < 2) t_rise[rc] = $realtime;
    rc = rc + 1;
  end

  // PHY model: presents the next response bit after a falling MDC edge.
  always @(negedge mdc)
    mdio_i = (present && rc >= 48 && rc < 64) ? resp[63 - rc] : 1'b1;

  function automatic logic [31:0] mk_word(input logic rd, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, rd ? 2'b10 : 2'b01, phy, rg, 2'b10, d};
  endfunction

  function automatic logic [31:0] exp_reg(input logic [31:0] w, input logic pres,
                                          input logic [15:0] r);
    if (!w[29]) return w;
    return {w[31:16], pres ? r : 16'hFFFF};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] w, input logic sel, input logic pres,
                           input logic [15:0] r, input bit hammer);
    bit pre_ok = 1, bits_ok = 1, oe_ok = 1;
    int wait_cyc = 0;
    present = pres; resp = r; rc = 0; mdio_i = 1'b1;
    @(negedge clk);
    div_sel = sel; maint_wdata = w; maint_wr = 1'b1;
    @(negedge clk);
    maint_wr = 1'b0;
    chk(idle == 1'b0, "R1", {31'd0, idle}, 32'd0);
    while (!idle && wait_cyc < 5000) begin
      if (hammer) begin maint_wr = 1'b1; maint_wdata = ~w; end
      @(negedge clk);
      wait_cyc++;
    end
    maint_wr = 1'b0;
    chk(rc == 64, "R11", rc, 64);
    for (int k = 0; k < 32; k++) if (!(obs_o[k] && obs_oe[k])) pre_ok = 0;
    chk(pre_ok, "R3", {31'd0, pre_ok}, 1);
    for (int k = 32; k < 64; k++) begin
      if (obs_oe[k] && obs_o[k] != w[63 - k]) bits_ok = 0;
      if (obs_oe[k] != !(w[29] && k >= 47)) oe_ok = 0;
    end
    chk(bits_ok, hammer ? "R4/R9" : "R4", {31'd0, bits_ok}, 1);
    chk(oe_ok, "R5", {31'd0, oe_ok}, 1);
    chk(maint_rdata == exp_reg(w, pres, r), w[29] ? "R6" : "R7", maint_rdata,
        exp_reg(w, pres, r));
    chk(int'((t_rise[1] - t_rise[0]) / 8.0) == (sel ? 48 : 32), "R8",
        int'((t_rise[1] - t_rise[0]) / 8.0), sel ? 48 : 32);
    chk(!mdc && !mdio_oe && idle, "R10", {29'd0, mdc, mdio_oe, idle}, 32'd1);
    if (hammer) begin
      repeat (100) @(negedge clk);
      chk(rc == 64 && maint_rdata == exp_reg(w, pres, r), "R9", maint_rdata,
          exp_reg(w, pres, r));
    end
  endtask

  initial begin
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(maint_rdata == 0 && !mdc && !mdio_oe && !idle, "R1", maint_rdata, 0);
    // Disabled port: write ignored.
    maint_wdata = mk_word(1, 5'd3, 5'd1, 16'h0); maint_wr = 1'b1;
    @(negedge clk);
    maint_wr = 1'b0;
    repeat (100) @(negedge clk);
    chk(rc == 0 && maint_rdata == 0 && !mdio_oe && !mdc, "R2", maint_rdata, 0);
    mgmt_en = 1'b1;
    @(negedge clk);
    chk(idle == 1'b1, "R1", {31'd0, idle}, 1);
    // Directed corners.
    run_frame(mk_word(1, 5'd31, 5'd1, 16'h0000), 1'b0, 1'b0, 16'h0, 0);
    run_frame(mk_word(1, 5'd0, 5'd2, 16'h1234), 1'b1, 1'b1, 16'h7949, 0);
    run_frame(mk_word(0, 5'd5, 5'd0, 16'hA5C3), 1'b0, 1'b0, 16'h0, 0);
    run_frame(mk_word(1, 5'd7, 5'd3, 16'h0), 1'b0, 1'b1, 16'h8001, 1);
    run_frame(mk_word(0, 5'd9, 5'd4, 16'hFFFF), 1'b1, 1'b0, 16'h0, 1);
    // Disable after traffic: register held.
    keep = maint_rdata;
    mgmt_en = 1'b0;
    maint_wdata = 32'h1234_5678; maint_wr = 1'b1;
    @(negedge clk);
    maint_wr = 1'b0;
    repeat (50) @(negedge clk);
    chk(maint_rdata == keep && !mdc, "R2", maint_rdata, keep);
    mgmt_en = 1'b1;
    // Random commands.
    for (int n = 0; n < 20; n++) begin
      logic [31:0] rv = $urandom;
      run_frame(mk_word(rv[0], rv[5:1], rv[10:6], rv[31:16]), rv[11], rv[12],
                16'($urandom), rv[13] && rv[14]);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule